// File: doc/BRIEF.md
# Table Entry Idle Timeout Tracker

This block watches every entry of a lookup table and reports entries that have sat unused for too long. Each entry holds a programmable time-to-live (TTL) and an idle age. A periodic sweep walks all entries, one per clock cycle, and adds one to each age. Every lookup that selects an entry resets that entry's age to zero. When an entry's age reaches its TTL, the block writes the entry index into a small output FIFO. The control plane drains that FIFO and decides whether to remove the entry.

A table-wide mode input chooses between no tracking at all and notification. A TTL of zero marks an entry that never ages out. The miss case has no timer. A lookup flagged as a miss changes nothing. An entry is reported once per idle period, and a later hit or TTL write arms it again. When the FIFO has no room, the entry keeps its pending state and is offered again on the next sweep.

Top module: `idle_timeout_tracker`

## Requirements
- R1: After reset, `note_valid` is 0 and every entry has TTL 0, so no entry reports until a TTL is written.
- R2: While `mode_notify` is 0, no entry is aged or reported, and all ages and report flags are cleared. After `mode_notify` returns to 1, every entry measures idle time from zero.
- R3: A sweep starts on every `TICK_DIV`-th pulse of `tick_in` counted while `mode_notify` is 1. Each sweep adds one to the age of every entry. Fewer pulses start no sweep.
- R4: An entry with a nonzero TTL is reported in the sweep where its age, counted in sweeps since its last hit or TTL write, first becomes greater than or equal to its TTL.
- R5: A hit (`hit_valid`=1, `hit_miss`=0) on an entry sets its age to zero and arms it again for a new report.
- R6: An entry whose TTL is 0 never produces a report in either mode.
- R7: A lookup with `hit_miss`=1 leaves all entries unchanged, whatever the value of `hit_idx`.
- R8: An entry is reported at most once per idle period. Further sweeps without a hit produce no repeat.
- R9: When the FIFO holds `FIFO_DEPTH` items, a due entry is not written and no item is lost. The entry stays pending and is reported on the next sweep that finds room.
- R10: Within one sweep, reports leave the FIFO in ascending entry order. While `note_valid`=1 and `note_ready`=0, `note_valid` and `note_idx` hold steady.
- R11: A TTL write sets the entry's TTL, clears its age and arms it again. Ages saturate at the largest TTL value, so an entry with the maximum TTL is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_notify | input | 1 | 1 = notify mode, 0 = no timeout |
| tick_in | input | 1 | Timebase pulse, one cycle wide |
| hit_valid | input | 1 | A lookup happened this cycle |
| hit_miss | input | 1 | The lookup missed (default action) |
| hit_idx | input | IDX_W | Entry selected by the lookup |
| cfg_valid | input | 1 | TTL write strobe |
| cfg_idx | input | IDX_W | Entry whose TTL is written |
| cfg_ttl | input | TTL_W | New TTL in sweeps; 0 = never expire |
| note_ready | input | 1 | Consumer takes the head report |
| note_valid | output | 1 | A report is waiting |
| note_idx | output | IDX_W | Index of the idle entry |

## Verification
The `TICK_DIV`-th tick is sampled on one edge, and the sweep becomes active on the next edge. Entry i is evaluated on the (i+2)-th edge after the tick. Its report is visible on `note_idx` right after that edge. Every report of a sweep is therefore due within `ENTRIES`+2 cycles of the final tick. The bench waits `ENTRIES`+4 cycles before it requires its scoreboard queue to be empty. Its monitor samples on the falling edge and compares each report against the queue head, so the exact cycle is not needed for comparison. A late or missing report is still caught at the end of that window.

// File: rtl/itt_pkg.sv
package itt_pkg;
  // Index width that stays at least one bit for tiny parameter values.
  function automatic int unsigned idx_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/itt_tick_prescaler.sv
module itt_tick_prescaler import itt_pkg::*; #(
  parameter int TICK_DIV = 4,
  localparam int CNT_W = idx_bits(TICK_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick_in,
  input  logic sweep_busy,
  output logic sweep_go
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q    <= '0;
      sweep_go <= 1'b0;
    end else begin
      sweep_go <= 1'b0;
      if (tick_in) begin
        if (cnt_q == CNT_W'(TICK_DIV - 1)) begin
          cnt_q    <= '0;
          sweep_go <= !sweep_busy;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // TICK_DIV is at least 2, so a start pulse is never two cycles long.
  assert_go_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    sweep_go |=> !sweep_go);
endmodule

// File: rtl/itt_sweeper.sv
module itt_sweeper import itt_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sweep_go,
  output logic             sweep_active,
  output logic [IDX_W-1:0] sweep_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_active <= 1'b0;
      sweep_idx    <= '0;
    end else if (sweep_active) begin
      if (sweep_idx == LAST) begin
        sweep_active <= 1'b0;
        sweep_idx    <= '0;
      end else begin
        sweep_idx <= sweep_idx + 1'b1;
      end
    end else if (sweep_go) begin
      sweep_active <= 1'b1;
      sweep_idx    <= '0;
    end
  end

  // Entries are visited in ascending order, one per cycle.
  assert_step_R10: assert property (@(posedge clk) disable iff (rst)
    sweep_active && $past(sweep_active) |-> sweep_idx == $past(sweep_idx) + 1'b1);
endmodule

// File: rtl/itt_entry_table.sv
module itt_entry_table import itt_pkg::*; #(
  parameter int ENTRIES = 16,
  parameter int TTL_W   = 4,
  localparam int IDX_W  = idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_notify,
  input  logic             hit_valid,
  input  logic             hit_miss,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [TTL_W-1:0] cfg_ttl,
  input  logic             sweep_active,
  input  logic [IDX_W-1:0] sweep_idx,
  input  logic             fifo_full,
  output logic             push_req,
  output logic [IDX_W-1:0] push_idx
);
  logic [TTL_W-1:0]   ttl_q [ENTRIES];
  logic [TTL_W-1:0]   age_q [ENTRIES];
  logic [ENTRIES-1:0] fired_q;

  logic [TTL_W-1:0] cur_age, nxt_age, cur_ttl;
  logic             cur_fired, touched, due;

  always_comb begin
    cur_age   = age_q[sweep_idx];
    cur_ttl   = ttl_q[sweep_idx];
    cur_fired = fired_q[sweep_idx];
    nxt_age   = (cur_age == {TTL_W{1'b1}}) ? cur_age : cur_age + 1'b1;
    // A hit or a TTL write on the swept entry wins over aging it.
    touched   = (cfg_valid && cfg_idx == sweep_idx) ||
                (hit_valid && !hit_miss && hit_idx == sweep_idx);
    due       = sweep_active && mode_notify && (cur_ttl != '0) &&
                !cur_fired && !touched && (nxt_age >= cur_ttl);
    push_req  = due && !fifo_full;
    push_idx  = sweep_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ttl_q[e] <= '0;
        age_q[e] <= '0;
      end
      fired_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (cfg_valid && cfg_idx == IDX_W'(e))
          ttl_q[e] <= cfg_ttl;
        if (!mode_notify ||
            (cfg_valid && cfg_idx == IDX_W'(e)) ||
            (hit_valid && !hit_miss && hit_idx == IDX_W'(e))) begin
          age_q[e]   <= '0;
          fired_q[e] <= 1'b0;
        end else if (sweep_active && sweep_idx == IDX_W'(e)) begin
          age_q[e] <= nxt_age;
          if (push_req)
            fired_q[e] <= 1'b1;
        end
      end
    end
  end

  assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    hit_valid && !hit_miss && mode_notify |=>
      age_q[$past(hit_idx)] == '0 && !fired_q[$past(hit_idx)]);

  assert_cfg_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> ttl_q[$past(cfg_idx)] == $past(cfg_ttl));

  assert_age_off_R2: assert property (@(posedge clk) disable iff (rst)
    !mode_notify |=> age_q[0] == '0 && fired_q == '0);
endmodule

// File: rtl/itt_note_fifo.sv
module itt_note_fifo import itt_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int W     = 4,
  localparam int PTR_W = idx_bits(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;
  logic             pop;

  assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign pop       = out_valid && pop_ready;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push)
      mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wrap_inc(wr_q);
      if (pop)  rd_q <= wrap_inc(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !pop_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/idle_timeout_tracker.sv
module idle_timeout_tracker import itt_pkg::*; #(
  parameter int ENTRIES    = 16,
  parameter int TTL_W      = 4,
  parameter int TICK_DIV   = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W     = idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_notify,
  input  logic             tick_in,
  input  logic             hit_valid,
  input  logic             hit_miss,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [TTL_W-1:0] cfg_ttl,
  input  logic             note_ready,
  output logic             note_valid,
  output logic [IDX_W-1:0] note_idx
);
  logic             sweep_go, sweep_active, fifo_full, push_req;
  logic [IDX_W-1:0] sweep_idx, push_idx;

  itt_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk(clk), .rst(rst), .enable(mode_notify), .tick_in(tick_in),
    .sweep_busy(sweep_active), .sweep_go(sweep_go)
  );

  itt_sweeper #(.ENTRIES(ENTRIES)) u_sweep (
    .clk(clk), .rst(rst), .sweep_go(sweep_go),
    .sweep_active(sweep_active), .sweep_idx(sweep_idx)
  );

  itt_entry_table #(.ENTRIES(ENTRIES), .TTL_W(TTL_W)) u_table (
    .clk(clk), .rst(rst), .mode_notify(mode_notify),
    .hit_valid(hit_valid), .hit_miss(hit_miss), .hit_idx(hit_idx),
    .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .cfg_ttl(cfg_ttl),
    .sweep_active(sweep_active), .sweep_idx(sweep_idx),
    .fifo_full(fifo_full), .push_req(push_req), .push_idx(push_idx)
  );

  itt_note_fifo #(.DEPTH(FIFO_DEPTH), .W(IDX_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push_req), .push_data(push_idx),
    .full(fifo_full), .pop_ready(note_ready),
    .out_valid(note_valid), .out_data(note_idx)
  );
endmodule

// File: tb/idle_timeout_tracker_tb.sv
module idle_timeout_tracker_tb;
  localparam int ENTRIES = 16;
  localparam int TTL_W   = 4;
  localparam int TICK_DIV = 4;
  localparam int DEPTH   = 4;
  localparam int IDX_W   = 4;
  localparam int MAXA    = (1 << TTL_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_notify = 1'b0, tick_in = 1'b0;
  logic hit_valid = 1'b0, hit_miss = 1'b0;
  logic [IDX_W-1:0] hit_idx = '0, cfg_idx = '0;
  logic cfg_valid = 1'b0;
  logic [TTL_W-1:0] cfg_ttl = '0;
  logic note_ready = 1'b1;
  logic note_valid;
  logic [IDX_W-1:0] note_idx;

  always #2 clk = ~clk;

  idle_timeout_tracker #(.ENTRIES(ENTRIES), .TTL_W(TTL_W), .TICK_DIV(TICK_DIV),
                         .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .mode_notify(mode_notify), .tick_in(tick_in),
    .hit_valid(hit_valid), .hit_miss(hit_miss), .hit_idx(hit_idx),
    .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .cfg_ttl(cfg_ttl),
    .note_ready(note_ready), .note_valid(note_valid), .note_idx(note_idx)
  );

  int checks = 0, fails = 0;
  int exp_q[$];
  int m_ttl[ENTRIES], m_age[ENTRIES], m_fired[ENTRIES];
  int m_mode = 0, m_tk = 0, m_cnt = 0;
  int mon_exp;

  // Monitor: each report popped is compared with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && note_valid && note_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: unexpected report idx=%0d, expected none", note_idx);
      end else begin
        mon_exp = exp_q.pop_front();
        if (int'(note_idx) != mon_exp) begin
          fails++;
          $display("FAIL R10: report idx=%0d, expected %0d", note_idx, mon_exp);
        end
      end
    end
  end

  task automatic model_sweep();
    for (int e = 0; e < ENTRIES; e++) begin
      m_age[e] = (m_age[e] < MAXA) ? m_age[e] + 1 : MAXA;
      if (m_ttl[e] != 0 && m_fired[e] == 0 && m_age[e] >= m_ttl[e]) begin
        if (note_ready || m_cnt < DEPTH) begin
          exp_q.push_back(e);
          m_fired[e] = 1;
          if (!note_ready) m_cnt++;
        end
      end
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_in = 1'b1;
      @(negedge clk) tick_in = 1'b0;
      if (m_mode != 0) begin
        m_tk++;
        if (m_tk == TICK_DIV) begin
          m_tk = 0;
          model_sweep();
        end
      end
    end
    repeat (ENTRIES + 4) @(negedge clk);
  endtask

  task automatic check_drained(string req);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d reports missing, head expected %0d, actual none",
               req, exp_q.size(), exp_q[0]);
      exp_q.delete();
    end
  endtask

  task automatic do_cfg(int idx, int ttl);
    @(negedge clk) begin cfg_valid = 1'b1; cfg_idx = IDX_W'(idx); cfg_ttl = TTL_W'(ttl); end
    @(negedge clk) cfg_valid = 1'b0;
    m_ttl[idx] = ttl; m_age[idx] = 0; m_fired[idx] = 0;
  endtask

  task automatic do_hit(int idx, bit miss);
    @(negedge clk) begin hit_valid = 1'b1; hit_miss = miss; hit_idx = IDX_W'(idx); end
    @(negedge clk) begin hit_valid = 1'b0; hit_miss = 1'b0; end
    if (!miss) begin m_age[idx] = 0; m_fired[idx] = 0; end
  endtask

  task automatic set_mode(int on);
    @(negedge clk) mode_notify = (on != 0);
    @(negedge clk);
    m_mode = on;
    if (on == 0) begin
      m_tk = 0;
      for (int e = 0; e < ENTRIES; e++) begin m_age[e] = 0; m_fired[e] = 0; end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    finish_run();
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) begin m_ttl[e] = 0; m_age[e] = 0; m_fired[e] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: nothing reported after reset
    checks++;
    if (note_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: note_valid=%0b, expected 0", note_valid);
    end

    // R2: mode off, TTL written but no aging or reports
    do_cfg(3, 1);
    ticks(2 * TICK_DIV);
    check_drained("R2");

    // R1/R3: enable; three pulses start no sweep, untouched entries have TTL 0
    set_mode(1);
    do_cfg(0, 1);
    do_cfg(1, 2);
    do_cfg(5, 0);
    ticks(TICK_DIV - 1);
    check_drained("R3");
    ticks(1);                 // R4: entries 0 and 3 due now
    check_drained("R4");
    ticks(TICK_DIV);          // R4: entry 1 due on second sweep
    check_drained("R4");
    ticks(2 * TICK_DIV);      // R8/R6: no repeats, entry 5 silent
    check_drained("R8");

    // R5: hit re-arms entry 0
    do_hit(0, 1'b0);
    ticks(TICK_DIV);
    check_drained("R5");

    // R7: miss lookup on entry 2 does not restart it
    do_cfg(2, 2);
    ticks(TICK_DIV);
    do_hit(2, 1'b1);
    ticks(TICK_DIV);
    check_drained("R7");

    // R11: maximum TTL still fires via saturating age
    do_cfg(7, MAXA);
    for (int s = 0; s < MAXA; s++) begin
      ticks(TICK_DIV);
      check_drained("R11");
    end

    // R9/R10: full FIFO keeps later entries pending
    for (int e = 8; e < 14; e++) do_cfg(e, 1);
    @(negedge clk) note_ready = 1'b0;
    m_cnt = 0;
    ticks(TICK_DIV);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      checks++;
      if (note_valid !== 1'b1 || int'(note_idx) != exp_q[0]) begin
        fails++;
        $display("FAIL R10: held valid=%0b idx=%0d, expected 1 idx=%0d",
                 note_valid, note_idx, exp_q[0]);
      end
    end
    @(negedge clk) note_ready = 1'b1;
    repeat (DEPTH + 4) @(negedge clk);
    check_drained("R9");
    m_cnt = 0;
    ticks(TICK_DIV);          // pending entries 12 and 13 retried
    check_drained("R9");

    // R2: turning tracking off clears idle time
    do_cfg(4, 3);
    ticks(2 * TICK_DIV);
    check_drained("R2");
    set_mode(0);
    set_mode(1);
    ticks(TICK_DIV);
    check_drained("R2");
    ticks(TICK_DIV);
    check_drained("R2");
    ticks(TICK_DIV);          // entry 4 only now reaches its TTL
    check_drained("R2");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule